// File: doc/BRIEF.md
# Interval Timer with One or Two Channels

This block is a register-mapped interval timer with one or two identical counting channels. A build parameter sets the number of channels. Software reaches it over a simple word-addressed bus with single-cycle read and write strobes. Each channel occupies a window of four words:

- word 0 is the control/status word;
- word 1 is the reload value;
- word 2 returns the live count;
- word 3 is unused.

The address bits above the two-bit word offset pick the channel.

Software sets a channel running by writing the control word with its enable bit set. The channel then copies the reload value into its counter and steps the counter once per clock, either downward towards zero or upward towards all-ones. When it passes the end, the channel raises its status flag. It then either reloads and keeps running, or clears its own enable bit and stops. One interrupt output carries the OR of every channel's status flag masked by that channel's interrupt-enable bit.

The control word also holds the bits for capture, generate output, PWM, cascade, load and enable-all. These bits are stored and read back but have no effect on counting.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous active-low reset, every control, reload and count register reads zero, `rdata` is zero and `irq` is low.
- R2: A write to word 0 stores bits 10:9 and 7:0 of `wdata` as written. Bits 31:11 read as zero. A read presents data on `rdata` one clock after the edge that samples `rd_en`.
- R3: A write to word 0 with bit 7 (enable) set loads the counter from word 1 at that edge. The counter steps from the following edge on, and this also applies when the channel is already running.
- R4: With bit 1 set (down mode), a running counter decrements by one per clock. While it holds zero, the next edge is an expiry. Word 2 returns the live count.
- R5: With bit 1 clear (up mode), a running counter increments by one per clock. While it holds 32'hFFFFFFFF, the next edge is an expiry.
- R6: An expiry sets status bit 8. If bit 4 (auto-reload) is set, the counter reloads from word 1 and bit 7 stays set. Otherwise bit 7 clears and the count holds.
- R7: Software never sets bit 8. Writing word 0 with bit 8 = 1 clears the status flag, and writing it with bit 8 = 0 leaves the flag unchanged.
- R8: `irq` is high exactly when some present channel has both bit 8 and bit 6 (interrupt enable) set.
- R9: A channel with bit 7 clear holds its count. Writes to word 2 and word 3 change nothing, and word 3 reads zero.
- R10: With NUM_CH = 1, the channel-1 window (word addresses 4 to 7) reads zero and ignores writes.
- R11: When an expiry and a word-0 write of the same channel fall on the same edge, bit 8 ends set whatever the written bit 8 is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address: channel in the upper bits, word in bits 1:0 |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Shared interrupt |

## Verification
The assertions assume that a strobe and its address and data are valid for exactly the cycle in which they are sampled. They also assume that `rd_en` and `wr_en` need not be exclusive, and that `wdata` is a full word. The stepping checks exclude only control-word writes as the cause of a counter jump, so they rely on the bench never writing any other way into the counter. The bench changes every bus input only on falling clock edges and holds each strobe for a single cycle. This also lets it land a status-clearing write on the exact edge of an expiry.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CTRL_W = 11;
  localparam int SEL_W  = ADDR_W - 2;
  localparam int B_DOWN = 1;
  localparam int B_AREL = 4;
  localparam int B_IEN  = 6;
  localparam int B_RUN  = 7;
  localparam int B_STAT = 8;
  localparam logic [DATA_W-1:0] TOP = '1;

  logic [CTRL_W-1:0] ctrl_q [NUM_CH];
  logic [DATA_W-1:0] load_q [NUM_CH];
  logic [DATA_W-1:0] cnt_q  [NUM_CH];
  logic [NUM_CH-1:0] flag;
  logic [DATA_W-1:0] rd_val;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wire sel     = addr[ADDR_W-1:2] == SEL_W'(ch);
    wire wr_ctrl = wr_en && sel && addr[1:0] == 2'd0;
    wire wr_load = wr_en && sel && addr[1:0] == 2'd1;
    wire run     = ctrl_q[ch][B_RUN];
    wire down    = ctrl_q[ch][B_DOWN];
    wire expire  = run && (down ? cnt_q[ch] == '0 : cnt_q[ch] == TOP);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[ch] <= '0;
        load_q[ch] <= '0;
        cnt_q[ch]  <= '0;
      end else begin
        if (wr_load) load_q[ch] <= wdata;
        if (wr_ctrl) begin
          ctrl_q[ch] <= {wdata[10:9], (ctrl_q[ch][B_STAT] & ~wdata[8]) | expire, wdata[7:0]};
          if (wdata[B_RUN]) cnt_q[ch] <= load_q[ch];
        end else if (run) begin
          if (expire) begin
            ctrl_q[ch][B_STAT] <= 1'b1;
            if (ctrl_q[ch][B_AREL]) cnt_q[ch] <= load_q[ch];
            else ctrl_q[ch][B_RUN] <= 1'b0;
          end else begin
            cnt_q[ch] <= down ? cnt_q[ch] - 1'b1 : cnt_q[ch] + 1'b1;
          end
        end
      end
    end

    assign flag[ch] = ctrl_q[ch][B_STAT] & ctrl_q[ch][B_IEN];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr[ADDR_W-1:2] == SEL_W'(i)) begin
        case (addr[1:0])
          2'd0:    rd_val = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q[i]};
          2'd1:    rd_val = load_q[i];
          2'd2:    rd_val = cnt_q[i];
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq = |flag;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [10:0]       ctrl_q [NUM_CH],
  input logic [DATA_W-1:0] load_q [NUM_CH],
  input logic [DATA_W-1:0] cnt_q  [NUM_CH]
);
  localparam logic [DATA_W-1:0] TOP = '1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wire cw = wr_en && addr == ADDR_W'(ch * 4);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cw && wdata[7]) |-> cnt_q[ch] == $past(load_q[ch])); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cw && ctrl_q[ch][7] && ctrl_q[ch][1] && cnt_q[ch] != '0)
      |-> cnt_q[ch] == $past(cnt_q[ch]) - DATA_W'(1)); // R4
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cw && ctrl_q[ch][7] && !ctrl_q[ch][1] && cnt_q[ch] != TOP)
      |-> cnt_q[ch] == $past(cnt_q[ch]) + DATA_W'(1)); // R5
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cw && ctrl_q[ch][7] && !ctrl_q[ch][4] &&
            (ctrl_q[ch][1] ? cnt_q[ch] == '0 : cnt_q[ch] == TOP))
      |-> !ctrl_q[ch][7] && ctrl_q[ch][8]); // R6
    AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[ch][8]) |-> $past(ctrl_q[ch][7])); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cw && !ctrl_q[ch][7]) |-> $stable(cnt_q[ch])); // R9
  end
endmodule

bind interval_timer interval_timer_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl_q(ctrl_q), .load_q(load_q), .cnt_q(cnt_q)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, s_rdata;
  logic        irq, s_irq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  logic [31:0] m_ctrl [2];
  logic [31:0] m_load [2];
  logic [31:0] m_cnt  [2];
  logic [31:0] exp_rd = '0;

  always #5 clk = ~clk;

  interval_timer #(.NUM_CH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  interval_timer #(.NUM_CH(1)) u_single (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(s_rdata), .irq(s_irq));

  function automatic logic [31:0] peek(input logic [2:0] a);
    int c = int'(a) / 4;
    case (a % 4)
      0: return m_ctrl[c];
      1: return m_load[c];
      2: return m_cnt[c];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_load[c] = 0; m_cnt[c] = 0;
      end
      exp_rd = 0;
    end else begin
      if (rd_en) exp_rd = peek(addr);
      for (int c = 0; c < 2; c++) begin
        logic [31:0] oc, ol, on;
        bit fin;
        oc = m_ctrl[c]; ol = m_load[c]; on = m_cnt[c];
        fin = oc[7] && (oc[1] ? on == 0 : on == 32'hFFFF_FFFF);
        if (wr_en && int'(addr) == 4 * c + 1) m_load[c] = wdata;
        if (wr_en && int'(addr) == 4 * c) begin
          m_ctrl[c] = wdata & 32'h6FF;
          m_ctrl[c][8] = (oc[8] && !wdata[8]) || fin;
          if (wdata[7]) m_cnt[c] = ol;
        end else if (oc[7]) begin
          if (fin) begin
            m_ctrl[c][8] = 1'b1;
            if (oc[4]) m_cnt[c] = ol;
            else m_ctrl[c][7] = 1'b0;
          end else begin
            m_cnt[c] = oc[1] ? on - 1 : on + 1;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R8 irq", {31'b0, irq},
          {31'b0, (m_ctrl[0][8] & m_ctrl[0][6]) | (m_ctrl[1][8] & m_ctrl[1][6])});
      chk("R10 single irq", {31'b0, s_irq}, {31'b0, m_ctrl[0][8] & m_ctrl[0][6]});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp_rd);
    chk({tag, " R10 single"}, s_rdata, (a >= 3'd4) ? 32'h0 : exp_rd);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    live = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), "R1 reset read", v);
      chk("R1 reset zero", v, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);

    wr(3'd1, 32'd5);
    wr(3'd0, 32'hFFFF_F2C7);
    rd(3'd0, "R2 ctrl", v);
    chk("R2 stored bits", v, 32'h0000_02C7);
    rd(3'd2, "R4 live count", v);
    chk("R4 R12 down count", v, 32'd2);
    idle(10);
    rd(3'd0, "R6 one-shot", v);
    chk("R6 stopped with status", v, 32'h0000_0347);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    rd(3'd2, "R9 held", v);
    chk("R9 count held at zero", v, 32'h0);
    wr(3'd2, 32'h1234);
    wr(3'd3, 32'h55);
    rd(3'd2, "R9 counter write", v);
    chk("R9 counter write ignored", v, 32'h0);
    rd(3'd3, "R9 spare word", v);
    chk("R9 spare word zero", v, 32'h0);

    wr(3'd0, 32'h042);
    rd(3'd0, "R7 keep", v);
    chk("R7 status kept on 0", v, 32'h142);
    wr(3'd0, 32'h142);
    rd(3'd0, "R7 clear", v);
    chk("R7 status cleared on 1", v, 32'h042);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h140);
    rd(3'd0, "R7 no set", v);
    chk("R7 software cannot set", v, 32'h040);

    wr(3'd1, 32'd100);
    wr(3'd0, 32'h082);
    rd(3'd2, "R3 start", v);
    chk("R3 loaded then stepped", v, 32'd99);
    wr(3'd0, 32'h082);
    rd(3'd2, "R3 restart", v);
    chk("R3 restart reloads", v, 32'd99);

    wr(3'd5, 32'hFFFF_FFFD);
    wr(3'd4, 32'h090);
    idle(10);
    rd(3'd4, "R6 auto-reload", v);
    chk("R6 R5 still running with status", {30'b0, v[8:7]}, 32'h3);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    rd(3'd6, "R5 up count", v);
    chk("R5 count near top", {31'b0, v >= 32'hFFFF_FFFD}, 32'h1);
    wr(3'd4, 32'h0D0);
    idle(2);
    chk("R8 irq from ch1", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h100);
    rd(3'd5, "R10 window", v);
    chk("R10 ch1 load on dual", v, 32'hFFFF_FFFD);

    wr(3'd1, 32'd2);
    wr(3'd0, 32'h082);
    idle(1);
    wr(3'd0, 32'h100);
    rd(3'd0, "R11 collision", v);
    chk("R11 expiry beats clear", v, 32'h100);

    idle(5);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule